// File: doc/BRIEF.md
# Multi-Queue Ring Buffer Manager

The block keeps 64 independent FIFO queues. All of them live as circular buffers inside one shared on-chip RAM of 2048 words of 32 bits (8 KB). Each queue has its own base word address, buffer length and entry length. It also has its own read pointer, write pointer, word count and two sticky error bits. A host issues one command at a time on a simple register-style port. The commands configure a queue, push or pop one word, read a queue's status word, or read and write the RAM directly by address. Software must give the queues regions that do not overlap, because the block does not check for overlap.

The status of the lower 32 queues is reported as a 32-bit flag vector. The upper 32 queues share one combined event line. There is one interrupt for each half.

A two-state controller sequences the port. In IDLE the port accepts any command. An accepted read-type command (pop, status read, RAM read) takes the IDLE→RESP transition. In RESP the response is presented for one cycle, and the controller then always returns RESP→IDLE. All other accepted commands, and idle cycles, stay on the IDLE→IDLE transition and complete in the accepting cycle.

Top module: `ringq_hub`

## Requirements
- R1: After reset every queue is empty, with base 0, 16-word buffer, 1-word entries, both select and enable bits clear, and no sticky errors. Its status word then reads 0x100. flag_lo, evt_hi, irq_lo and irq_hi are 0, rsp_valid is 0 and cmd_ready is 1.
- R2: The configure command (op 1) writes the fields of cmd_wdata into queue cmd_qid:
  - base in bits [10:0];
  - buffer code in [12:11], giving 16, 32, 64 or 128 words;
  - entry code in [14:13], giving 1, 2, 4 or 4 words;
  - status select in bit 15;
  - event enable in bit 16.
  It also clears that queue's pointers, count and sticky bits.
- R3: A push (op 2) that is not refused stores cmd_wdata at RAM word (base + write pointer) mod 2048. The write pointer then advances modulo the buffer length. Pops return words in push order across pointer wrap.
- R4: A pop (op 3) returns the oldest word on rsp_data with rsp_valid high in the cycle after acceptance, and advances the read pointer modulo the buffer length. Every read-type command responds this way, and cmd_ready is low during the response cycle.
- R5: A push to a queue holding as many words as its buffer length is dropped. Stored data and the count are unchanged, and a sticky overflow bit is set.
- R6: A pop from a queue holding no words returns zero and sets a sticky underflow bit.
- R7: Flags work at entry granularity. A queue is empty while its word count is below the entry length. It is full while the free words are fewer than the entry length.
- R8: The status read (op 4) returns count in [7:0], empty in bit 8, full in bit 9, underflow in bit 10 and overflow in bit 11. All other bits are zero.
- R9: flag_lo[i] for queue i below 32 is the full flag when that queue's select bit is 1, and not-empty otherwise.
- R10: evt_hi is the OR, over queues 32 to 63, of each queue's selected status bit AND its enable bit.
- R11: irq_lo is the OR over queues 0 to 31 of (selected status AND enable) OR underflow OR overflow. irq_hi is the same over queues 32 to 63.
- R12: The RAM write (op 5) stores cmd_wdata at cmd_addr. The RAM read (op 6) returns the word at cmd_addr with R4 timing.
- R13: Op 0 and op 7 change no queue state and give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_op | input | 3 | Command code |
| cmd_qid | input | 6 | Target queue |
| cmd_addr | input | 11 | RAM word address for direct access |
| cmd_wdata | input | 32 | Push data, configuration word or RAM write data |
| rsp_valid | output | 1 | Response data valid |
| rsp_data | output | 32 | Pop data, status word or RAM read data |
| flag_lo | output | 32 | Per-queue selected status, queues 0 to 31 |
| evt_hi | output | 1 | Combined enabled status, queues 32 to 63 |
| irq_lo | output | 1 | Interrupt for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt for queues 32 to 63 |

## Verification
The hardest states to reach from the ports are the boundaries of a large buffer with multi-word entries. Examples are a 128-word queue with 4-word entries that turns full while three words are still free, and a queue whose base sits near the top of the RAM, so its addresses wrap past word 2047 while its pointer also wraps. The stimulus reaches these by filling such queues word by word to the exact count and by draining and refilling a queue past its wrap point. Direct RAM reads then confirm where each word landed. A behavioural model compares flags, event, interrupts and responses on every clock.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

    localparam int PTR_W = 7;   // pointer width, largest buffer is 128 words
    localparam int CNT_W = 8;   // word count width, up to 128

    // configuration word field positions
    localparam int CFG_SZ_LSB  = 11;
    localparam int CFG_ENT_LSB = 13;
    localparam int CFG_SEL_BIT = 15;
    localparam int CFG_EN_BIT  = 16;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CFG   = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_STAT  = 3'd4,
        OP_RAMWR = 3'd5,
        OP_RAMRD = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } fsm_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_RAM,
        SRC_ZERO,
        SRC_STAT
    } src_e;

    typedef struct packed {
        logic             ov;
        logic             uf;
        logic             full;
        logic             empty;
        logic [CNT_W-1:0] cnt;
    } qstat_t;

    function automatic logic [CNT_W-1:0] size_words(input logic [1:0] code);
        return CNT_W'(16) << code;
    endfunction

    function automatic logic [CNT_W-1:0] ent_words(input logic [1:0] code);
        logic [CNT_W-1:0] w;
        unique case (code)
            2'd0:    w = CNT_W'(1);
            2'd1:    w = CNT_W'(2);
            default: w = CNT_W'(4);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ringq_ram.sv
module ringq_ram #(
    parameter int AW = 11,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/ringq_state.sv
module ringq_state
    import ringq_pkg::*;
#(
    parameter int NQ = 64,
    parameter int AW = 11,
    localparam int QW = $clog2(NQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                push_req,
    input  logic                pop_req,
    input  logic [QW-1:0]       qid,
    input  logic [CFG_EN_BIT:0] cfg_word,
    output logic [AW-1:0]       sel_base,
    output logic [PTR_W-1:0]    sel_wr,
    output logic [PTR_W-1:0]    sel_rd,
    output logic [CNT_W-1:0]    sel_size,
    output qstat_t              sel_stat,
    output logic [NQ-1:0]       empty_v,
    output logic [NQ-1:0]       full_v,
    output logic [NQ-1:0]       sel_v,
    output logic [NQ-1:0]       en_v,
    output logic [NQ-1:0]       uf_v,
    output logic [NQ-1:0]       ov_v
);

    logic [AW-1:0]    base_a [NQ];
    logic [PTR_W-1:0] wr_a   [NQ];
    logic [PTR_W-1:0] rd_a   [NQ];
    logic [CNT_W-1:0] cnt_a  [NQ];
    logic [CNT_W-1:0] szw_a  [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [AW-1:0]    base_q;
        logic [1:0]       szc_q, entc_q;
        logic             sel_q, en_q, uf_q, ov_q;
        logic [PTR_W-1:0] wr_q, rd_q;
        logic [CNT_W-1:0] cnt_q;
        logic             hit;
        logic [CNT_W-1:0] szw, entw;
        logic [PTR_W-1:0] mask;

        assign hit  = (qid == QW'(g));
        assign szw  = size_words(szc_q);
        assign entw = ent_words(entc_q);
        assign mask = PTR_W'(szw - CNT_W'(1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q <= '0;
                szc_q  <= '0;
                entc_q <= '0;
                sel_q  <= 1'b0;
                en_q   <= 1'b0;
                wr_q   <= '0;
                rd_q   <= '0;
                cnt_q  <= '0;
                uf_q   <= 1'b0;
                ov_q   <= 1'b0;
            end else if (hit && cfg_we) begin
                base_q <= cfg_word[AW-1:0];
                szc_q  <= cfg_word[CFG_SZ_LSB +: 2];
                entc_q <= cfg_word[CFG_ENT_LSB +: 2];
                sel_q  <= cfg_word[CFG_SEL_BIT];
                en_q   <= cfg_word[CFG_EN_BIT];
                wr_q   <= '0;
                rd_q   <= '0;
                cnt_q  <= '0;
                uf_q   <= 1'b0;
                ov_q   <= 1'b0;
            end else if (hit && push_req) begin
                if (cnt_q == szw) begin
                    ov_q <= 1'b1;
                end else begin
                    wr_q  <= (wr_q + PTR_W'(1)) & mask;
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (hit && pop_req) begin
                if (cnt_q == '0) begin
                    uf_q <= 1'b1;
                end else begin
                    rd_q  <= (rd_q + PTR_W'(1)) & mask;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end

        assign base_a[g]  = base_q;
        assign wr_a[g]    = wr_q;
        assign rd_a[g]    = rd_q;
        assign cnt_a[g]   = cnt_q;
        assign szw_a[g]   = szw;
        assign empty_v[g] = (cnt_q < entw);
        assign full_v[g]  = ((szw - cnt_q) < entw);
        assign sel_v[g]   = sel_q;
        assign en_v[g]    = en_q;
        assign uf_v[g]    = uf_q;
        assign ov_v[g]    = ov_q;
    end

    assign sel_base       = base_a[qid];
    assign sel_wr         = wr_a[qid];
    assign sel_rd         = rd_a[qid];
    assign sel_size       = szw_a[qid];
    assign sel_stat.cnt   = cnt_a[qid];
    assign sel_stat.empty = empty_v[qid];
    assign sel_stat.full  = full_v[qid];
    assign sel_stat.uf    = uf_v[qid];
    assign sel_stat.ov    = ov_v[qid];

endmodule

// File: rtl/ringq_status.sv
module ringq_status #(
    parameter int NQ = 64,
    localparam int HALF = NQ / 2
) (
    input  logic [NQ-1:0]   empty_v,
    input  logic [NQ-1:0]   full_v,
    input  logic [NQ-1:0]   sel_v,
    input  logic [NQ-1:0]   en_v,
    input  logic [NQ-1:0]   uf_v,
    input  logic [NQ-1:0]   ov_v,
    output logic [HALF-1:0] flag_lo,
    output logic            evt_hi,
    output logic            irq_lo,
    output logic            irq_hi
);

    logic [NQ-1:0] chosen;
    logic [NQ-1:0] armed;

    for (genvar g = 0; g < NQ; g++) begin : g_pick
        assign chosen[g] = sel_v[g] ? full_v[g] : ~empty_v[g];
        assign armed[g]  = chosen[g] & en_v[g];
    end

    assign flag_lo = chosen[HALF-1:0];
    assign evt_hi  = |armed[NQ-1:HALF];
    assign irq_lo  = (|armed[HALF-1:0]) | (|uf_v[HALF-1:0]) | (|ov_v[HALF-1:0]);
    assign irq_hi  = evt_hi | (|uf_v[NQ-1:HALF]) | (|ov_v[NQ-1:HALF]);

endmodule

// File: rtl/ringq_hub.sv
module ringq_hub
    import ringq_pkg::*;
#(
    parameter int NQ = 64,
    parameter int AW = 11,
    parameter int DW = 32,
    localparam int QW = $clog2(NQ),
    localparam int HALF = NQ / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [2:0]      cmd_op,
    input  logic [QW-1:0]   cmd_qid,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [HALF-1:0] flag_lo,
    output logic            evt_hi,
    output logic            irq_lo,
    output logic            irq_hi
);

    fsm_e   state_q, state_d;
    src_e   src_q, src_d;
    qstat_t stat_q, q_stat;
    op_e    op;
    logic   accept;

    logic             cfg_we, push_req, pop_req;
    logic             ram_we, ram_re;
    logic [AW-1:0]    ram_waddr, ram_raddr;
    logic [DW-1:0]    ram_q;
    logic [AW-1:0]    q_base;
    logic [PTR_W-1:0] q_wr, q_rd;
    logic [CNT_W-1:0] q_size, q_cnt;
    logic             has_word, has_room;
    logic [NQ-1:0]    empty_v, full_v, sel_v, en_v, uf_v, ov_v;

    assign op       = op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign q_cnt    = q_stat.cnt;
    assign has_word = (q_cnt != '0);
    assign has_room = (q_cnt != q_size);

    // command decode: strobes into queue state and RAM
    always_comb begin
        cfg_we    = 1'b0;
        push_req  = 1'b0;
        pop_req   = 1'b0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_waddr = cmd_addr;
        ram_raddr = cmd_addr;
        if (accept) begin
            unique case (op)
                OP_CFG:   cfg_we = 1'b1;
                OP_PUSH: begin
                    push_req  = 1'b1;
                    ram_we    = has_room;
                    ram_waddr = q_base + AW'(q_wr);
                end
                OP_POP: begin
                    pop_req   = 1'b1;
                    ram_re    = has_word;
                    ram_raddr = q_base + AW'(q_rd);
                end
                OP_RAMWR: ram_we = 1'b1;
                OP_RAMRD: ram_re = 1'b1;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_POP: begin
                            state_d = ST_RESP;
                            src_d   = has_word ? SRC_RAM : SRC_ZERO;
                        end
                        OP_STAT: begin
                            state_d = ST_RESP;
                            src_d   = SRC_STAT;
                        end
                        OP_RAMRD: begin
                            state_d = ST_RESP;
                            src_d   = SRC_RAM;
                        end
                        default: ;
                    endcase
                end
            end
            ST_RESP: begin
                state_d = ST_IDLE;
                src_d   = SRC_NONE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_NONE;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            if (accept && op == OP_STAT) begin
                stat_q <= q_stat;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        unique case (src_q)
            SRC_RAM:  rsp_data = ram_q;
            SRC_STAT: rsp_data = DW'(stat_q);
            default:  rsp_data = '0;
        endcase
    end

    ringq_state #(.NQ(NQ), .AW(AW)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .push_req (push_req),
        .pop_req  (pop_req),
        .qid      (cmd_qid),
        .cfg_word (cmd_wdata[CFG_EN_BIT:0]),
        .sel_base (q_base),
        .sel_wr   (q_wr),
        .sel_rd   (q_rd),
        .sel_size (q_size),
        .sel_stat (q_stat),
        .empty_v  (empty_v),
        .full_v   (full_v),
        .sel_v    (sel_v),
        .en_v     (en_v),
        .uf_v     (uf_v),
        .ov_v     (ov_v)
    );

    ringq_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (cmd_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_q)
    );

    ringq_status #(.NQ(NQ)) u_status (
        .empty_v (empty_v),
        .full_v  (full_v),
        .sel_v   (sel_v),
        .en_v    (en_v),
        .uf_v    (uf_v),
        .ov_v    (ov_v),
        .flag_lo (flag_lo),
        .evt_hi  (evt_hi),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

endmodule

// File: rtl/ringq_hub_chk.sv
module ringq_hub_chk
    import ringq_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic             rsp_valid,
    input logic [DW-1:0]    rsp_data,
    input logic             evt_hi,
    input logic             irq_hi,
    input logic [CNT_W-1:0] q_cnt
);

    logic take_rd, take_pop;
    assign take_rd  = cmd_valid && cmd_ready &&
                      (cmd_op == OP_POP || cmd_op == OP_STAT || cmd_op == OP_RAMRD);
    assign take_pop = cmd_valid && cmd_ready && (cmd_op == OP_POP);

    // R4: read-type command answered in the next cycle
    p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd |=> rsp_valid);

    // R4: no new command taken while a response is shown
    p_busy_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R4: every response has an accepted read behind it
    p_rsp_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(take_rd));

    // R6: popping an empty queue yields zero
    p_empty_pop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pop && q_cnt == '0) |=> (rsp_valid && rsp_data == '0));

    // R11: upper event always reaches the upper interrupt
    p_evt_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hi |-> irq_hi);

endmodule

bind ringq_hub ringq_hub_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .evt_hi    (evt_hi),
    .irq_hi    (irq_hi),
    .q_cnt     (q_cnt)
);

// File: tb/test_ringq_hub.sv
`timescale 1ns/1ps
module test_ringq_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_qid = '0;
    logic [10:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [31:0] flag_lo;
    logic        evt_hi, irq_lo, irq_hi;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ringq_hub i_ringq_hub (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_qid(cmd_qid), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flag_lo(flag_lo),
        .evt_hi(evt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // behavioural model
    int m_base[64], m_szc[64], m_entc[64], m_sel[64], m_en[64];
    int m_wr[64], m_rd[64], m_cnt[64], m_uf[64], m_ov[64];
    int m_ram[2048];

    bit          exp_rv = 1'b0;
    logic [31:0] exp_rd = '0;
    string       exp_tag = "R4";

    function automatic int msize(int q); return 16 << m_szc[q]; endfunction
    function automatic int ment(int q); return (m_entc[q] == 0) ? 1 : (m_entc[q] == 1) ? 2 : 4; endfunction
    function automatic int mempty(int q); return (m_cnt[q] < ment(q)) ? 1 : 0; endfunction
    function automatic int mfull(int q); return ((msize(q) - m_cnt[q]) < ment(q)) ? 1 : 0; endfunction
    function automatic int mchosen(int q); return m_sel[q] != 0 ? mfull(q) : 1 - mempty(q); endfunction

    task automatic chk(input string tag, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] ef;
        logic ee, eil, eih;
        ef = '0; ee = 0; eil = 0; eih = 0;
        for (int q = 0; q < 64; q++) begin
            if (q < 32) begin
                ef[q] = mchosen(q)[0];
                eil |= (mchosen(q) != 0 && m_en[q] != 0) || m_uf[q] != 0 || m_ov[q] != 0;
            end else begin
                ee  |= (mchosen(q) != 0 && m_en[q] != 0);
                eih |= (mchosen(q) != 0 && m_en[q] != 0) || m_uf[q] != 0 || m_ov[q] != 0;
            end
        end
        chk("R9 flag_lo", flag_lo, ef);
        chk("R10 evt_hi", evt_hi, ee);
        chk("R11 irq_lo", irq_lo, eil);
        chk("R11 irq_hi", irq_hi, eih);
        chk("R4 cmd_ready", cmd_ready, !exp_rv);
        chk("R4 rsp_valid", rsp_valid, exp_rv);
        if (exp_rv) chk(exp_tag, rsp_data, exp_rd);
    end

    function automatic logic [31:0] cfgw(int base, int szc, int entc, int sel, int en);
        return 32'(base) | 32'(szc << 11) | 32'(entc << 13) | 32'(sel << 15) | 32'(en << 16);
    endfunction

    task automatic cmd(input int op, input int q, input int addr, input logic [31:0] d, input string tag);
        bit rd;
        int a;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_qid = 6'(q); cmd_addr = 11'(addr); cmd_wdata = d;
        @(posedge clk);
        #1;
        rd = 0;
        case (op)
            1: begin
                m_base[q] = int'(d[10:0]); m_szc[q] = int'(d[12:11]); m_entc[q] = int'(d[14:13]);
                m_sel[q] = int'(d[15]); m_en[q] = int'(d[16]);
                m_wr[q] = 0; m_rd[q] = 0; m_cnt[q] = 0; m_uf[q] = 0; m_ov[q] = 0;
            end
            2: begin
                if (m_cnt[q] == msize(q)) m_ov[q] = 1;
                else begin
                    a = (m_base[q] + m_wr[q]) % 2048;
                    m_ram[a] = int'(d);
                    m_wr[q] = (m_wr[q] + 1) % msize(q);
                    m_cnt[q]++;
                end
            end
            3: begin
                rd = 1;
                if (m_cnt[q] == 0) begin m_uf[q] = 1; exp_rd = '0; end
                else begin
                    a = (m_base[q] + m_rd[q]) % 2048;
                    exp_rd = 32'(m_ram[a]);
                    m_rd[q] = (m_rd[q] + 1) % msize(q);
                    m_cnt[q]--;
                end
            end
            4: begin
                rd = 1;
                exp_rd = 32'(m_cnt[q]) | 32'(mempty(q) << 8) | 32'(mfull(q) << 9)
                       | 32'(m_uf[q] << 10) | 32'(m_ov[q] << 11);
            end
            5: m_ram[addr] = int'(d);
            6: begin rd = 1; exp_rd = 32'(m_ram[addr]); end
            default: ;
        endcase
        exp_rv = rd;
        exp_tag = tag;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (rd) begin
            @(posedge clk);
            #1;
            exp_rv = 1'b0;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int q = 0; q < 64; q++) begin
            m_base[q] = 0; m_szc[q] = 0; m_entc[q] = 0; m_sel[q] = 0; m_en[q] = 0;
            m_wr[q] = 0; m_rd[q] = 0; m_cnt[q] = 0; m_uf[q] = 0; m_ov[q] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset status of an untouched queue reads 0x100
        cmd(4, 5, 0, 0, "R1 reset status");
        chk("R1 reset status value", 32'h100, 32'(mempty(5) << 8));

        // R2, R3, R4: small queue, FIFO order and placement
        cmd(1, 0, 0, cfgw(500, 0, 0, 0, 1), "R2");
        for (int i = 0; i < 3; i++) cmd(2, 0, 0, 32'hA0 + 32'(i), "R3");
        cmd(6, 0, 501, 0, "R3 placement");
        cmd(4, 0, 0, 0, "R8 status");
        for (int i = 0; i < 3; i++) cmd(3, 0, 0, 0, "R4 pop order");

        // R5, R6, R7: 16-word queue, 2-word entries, full select
        cmd(1, 1, 0, cfgw(100, 0, 1, 1, 1), "R2");
        for (int i = 0; i < 14; i++) cmd(2, 1, 0, 32'h1000 + 32'(i), "R3");
        cmd(4, 1, 0, 0, "R7 not yet full");
        cmd(2, 1, 0, 32'h100E, "R7");
        cmd(4, 1, 0, 0, "R7 full at 15");
        cmd(2, 1, 0, 32'h100F, "R3");
        cmd(2, 1, 0, 32'hBAD0BAD0, "R5 push to full");
        cmd(4, 1, 0, 0, "R5 overflow sticky");
        for (int i = 0; i < 16; i++) cmd(3, 1, 0, 0, "R5 contents kept");
        cmd(3, 1, 0, 0, "R6 empty pop");
        cmd(4, 1, 0, 0, "R6 underflow sticky");
        cmd(1, 1, 0, cfgw(100, 0, 1, 1, 1), "R2");
        cmd(4, 1, 0, 0, "R2 clears sticky");

        // R3: pointer wrap and RAM address wrap
        cmd(1, 2, 0, cfgw(2040, 0, 0, 0, 0), "R2");
        for (int i = 0; i < 10; i++) cmd(2, 2, 0, 32'h2000 + 32'(i), "R3");
        for (int i = 0; i < 10; i++) cmd(3, 2, 0, 0, "R3 pop");
        for (int i = 0; i < 12; i++) cmd(2, 2, 0, 32'h2100 + 32'(i), "R3");
        cmd(6, 0, 2, 0, "R3 address wrap");
        for (int i = 0; i < 12; i++) cmd(3, 2, 0, 0, "R3 wrap order");

        // R7: 128-word queue with 4-word entries
        cmd(1, 3, 0, cfgw(1024, 3, 2, 0, 0), "R2");
        for (int i = 0; i < 3; i++) cmd(2, 3, 0, 32'h3000 + 32'(i), "R3");
        cmd(4, 3, 0, 0, "R7 partial entry empty");
        for (int i = 3; i < 125; i++) cmd(2, 3, 0, 32'h3000 + 32'(i), "R3");
        cmd(4, 3, 0, 0, "R7 full with 3 free");
        cmd(3, 3, 0, 0, "R4");
        cmd(4, 3, 0, 0, "R7 full cleared");

        // R10, R11: upper half
        cmd(1, 63, 0, cfgw(1200, 0, 2, 1, 1), "R2");
        for (int i = 0; i < 13; i++) cmd(2, 63, 0, 32'h6300 + 32'(i), "R10");
        cmd(3, 63, 0, 0, "R10 pop clears full");
        cmd(1, 40, 0, cfgw(1300, 0, 0, 0, 0), "R2");
        cmd(2, 40, 0, 32'h4000, "R10 disabled queue");
        cmd(1, 40, 0, cfgw(1300, 0, 0, 0, 1), "R2");
        cmd(2, 40, 0, 32'h4001, "R10 enabled queue");
        cmd(3, 40, 0, 0, "R4");
        cmd(3, 50, 0, 0, "R11 underflow upper");

        // R12: direct RAM access
        cmd(5, 0, 1500, 32'hDEADBEEF, "R12");
        cmd(6, 0, 1500, 0, "R12 ram read");

        // R13: reserved commands have no effect
        cmd(2, 0, 0, 32'h77, "R3");
        cmd(0, 0, 0, 32'h1, "R13");
        cmd(7, 0, 0, 32'h1, "R13");
        cmd(4, 0, 0, 0, "R13 status unchanged");
        cmd(3, 0, 0, 0, "R13 data unchanged");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule